// File: doc/BRIEF.md
# Per-Bank External Memory Strobe Controller

This block generates the external memory control strobes for a 20-bit physical address space that is divided into four equal banks. The bank is chosen by the two most significant address bits. Each bank has its own 8-bit control byte, and the block uses the byte of the bank being accessed. The byte sets four things for that bank: how many wait states an access takes, which of three chip selects is driven, which output-enable/write-enable pair is used, and whether the bank is read-only. It can also invert either of the two top address lines on the way out to the memory.

Requests arrive on a valid/ready handshake. `req_ready` is high only while no access is in progress. A request is taken in the cycle where `req_valid` and `req_ready` are both high. A requester facing a low `req_ready` keeps `req_valid`, `req_write` and `req_addr` steady until acceptance. At acceptance the block captures the address, the direction and the bank's control byte. It then holds the strobes for the programmed number of cycles and pulses `done` in the last one. A write always costs one wait state more than a read at the same setting. The control bytes are loaded through a simple byte-wide register write port.

Top module: `membank_ctl`

## Requirements
- R1: After reset all four control bytes are 0x00. `cs_n`, `oe_n` and `we_n` are all high, `done` is low, `req_ready` is high and `mem_addr` is zero.
- R2: A register write to address 0x14, 0x15, 0x16 or 0x17 loads the control byte of bank 0, 1, 2 or 3. A write to any other address changes no bank's behaviour.
- R3: The bank of an access is `req_addr[19:18]`, and that bank's control byte governs the access.
- R4: Strobes become active in the cycle after acceptance and stay active for W+1 cycles. `done` is high for exactly one cycle, the last of them. For reads, W is 4, 2, 1 or 0 for control bits [7:6] = 00, 01, 10 or 11.
- R5: For writes, W is one greater than for reads at the same code: 5, 3, 2 or 1.
- R6: Control bits [1:0] = 0, 1 or 2 drive `cs_n[0]`, `cs_n[1]` or `cs_n[2]` low for the access. Code 3 drives no chip select, and the access still completes with its normal timing.
- R7: Control bit [2] selects strobe pair 0 or 1. Control bit [3] = 1 makes the bank read-only: `we_n` stays high on writes, while chip select, write timing and `done` are unchanged.
- R8: During an access `mem_addr[19]` is `req_addr[19]` XOR control bit [5], and `mem_addr[18]` is `req_addr[18]` XOR control bit [4]. `mem_addr[17:0]` passes unchanged. `mem_addr` is zero while idle.
- R9: `req_ready` is low from the cycle after acceptance until the access ends. The control byte is captured at acceptance, so a register write during an access does not affect that access.
- R10: `oe_n` of the selected pair is low only during reads, and `we_n` only during writes. The two are never low at the same time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 8 | Register write address |
| cfg_wdata | input | 8 | Register write data |
| req_valid | input | 1 | Access request valid |
| req_ready | output | 1 | Block idle, request can be taken |
| req_write | input | 1 | 1 = write access, 0 = read |
| req_addr | input | 20 | Physical address of the access |
| cs_n | output | 3 | Active-low chip selects |
| oe_n | output | 2 | Active-low output enables |
| we_n | output | 2 | Active-low write enables |
| mem_addr | output | 20 | Address to memory, top two bits possibly inverted |
| done | output | 1 | One-cycle pulse in the last cycle of an access |

## Verification
Two situations are the hardest to reach from the ports. The first is a control byte rewritten while an access using that same bank is still stretching its wait states. The bench starts a slow read and writes a fast setting to the bank in the middle of it. It checks that the running access keeps its old length and strobes and that the next access uses the new ones. The second is a write to a read-only bank whose chip-select code is reserved, where no strobe moves at all. For that case the bench measures the access length only through the `done` pulse.

// File: rtl/membank_pkg.sv
package membank_pkg;

  localparam int NUM_BANKS = 4;
  localparam int NUM_CS    = 3;
  localparam int NUM_PAIRS = 2;
  localparam int WAIT_W    = 3;

  // Field order mirrors the control byte layout, bit 7 first
  typedef struct packed {
    logic [1:0] speed;    // [7:6] wait-state code
    logic       flip_hi;  // [5]   invert top address bit
    logic       flip_lo;  // [4]   invert second address bit
    logic       rd_only;  // [3]   suppress write enable
    logic       pair;     // [2]   strobe pair
    logic [1:0] csel;     // [1:0] chip select code
  } bank_cfg_t;

  function automatic logic [WAIT_W-1:0] wait_count(input logic [1:0] speed,
                                                    input logic is_wr);
    logic [WAIT_W-1:0] base;
    case (speed)
      2'b00:   base = 3'd4;
      2'b01:   base = 3'd2;
      2'b10:   base = 3'd1;
      default: base = 3'd0;
    endcase
    return base + {2'b00, is_wr};
  endfunction

endpackage

// File: rtl/membank_regs.sv
module membank_regs
  import membank_pkg::*;
#(
  parameter int                CFG_AW   = 8,
  parameter logic [CFG_AW-1:0] REG_BASE = 8'h14
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cfg_we,
  input  logic [CFG_AW-1:0]      cfg_addr,
  input  logic [7:0]             cfg_wdata,
  output logic [NUM_BANKS*8-1:0] cfg_flat
);

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    localparam logic [CFG_AW-1:0] MY_ADDR = REG_BASE + CFG_AW'(b);
    always_ff @(posedge clk) begin
      if (!rst_n)
        cfg_flat[b*8 +: 8] <= 8'h00;
      else if (cfg_we && cfg_addr == MY_ADDR)
        cfg_flat[b*8 +: 8] <= cfg_wdata;
    end
  end

  logic in_window;
  assign in_window = (cfg_addr >= REG_BASE) &&
                     (cfg_addr <  REG_BASE + CFG_AW'(NUM_BANKS));

  // R2
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(cfg_we && in_window) |=> $stable(cfg_flat));

endmodule

// File: rtl/membank_seq.sv
module membank_seq
  import membank_pkg::*;
#(
  parameter int ADDR_W = 20
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req_valid,
  input  logic                   req_write,
  input  logic [ADDR_W-1:0]      req_addr,
  input  logic [NUM_BANKS*8-1:0] cfg_flat,
  output logic                   req_ready,
  output logic                   busy,
  output logic                   done,
  output bank_cfg_t              act_cfg,
  output logic                   act_write,
  output logic [ADDR_W-1:0]      act_addr
);

  localparam int BANK_W = $clog2(NUM_BANKS);

  logic [BANK_W-1:0] bank_sel;
  bank_cfg_t         sel_cfg;
  logic [WAIT_W-1:0] cnt;
  logic              accept;

  assign bank_sel  = req_addr[ADDR_W-1 -: BANK_W];
  assign sel_cfg   = bank_cfg_t'(cfg_flat[32'(bank_sel)*8 +: 8]);
  assign req_ready = !busy;
  assign accept    = req_valid && !busy;
  assign done      = busy && (cnt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      cnt       <= '0;
      act_cfg   <= '0;
      act_write <= 1'b0;
      act_addr  <= '0;
    end else if (accept) begin
      busy      <= 1'b1;
      cnt       <= wait_count(sel_cfg.speed, req_write);
      act_cfg   <= sel_cfg;
      act_write <= req_write;
      act_addr  <= req_addr;
    end else if (busy) begin
      if (cnt == '0) busy <= 1'b0;
      else           cnt  <= cnt - 1'b1;
    end
  end

  // Independent up-counter of cycles spent in the current access
  logic [WAIT_W:0] elapsed;
  always_ff @(posedge clk) begin
    if (!rst_n || accept) elapsed <= '0;
    else if (busy)        elapsed <= elapsed + 1'b1;
  end

  // R4 R5
  wait_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> elapsed == {1'b0, wait_count(act_cfg.speed, act_write)});

  // R4
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done && !busy);

  // R9
  cfg_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && $past(busy) |-> $stable(act_cfg) && $stable(act_addr));

endmodule

// File: rtl/membank_strobe.sv
module membank_strobe
  import membank_pkg::*;
#(
  parameter int ADDR_W = 20
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 busy,
  input  bank_cfg_t            act_cfg,
  input  logic                 act_write,
  input  logic [ADDR_W-1:0]    act_addr,
  output logic [NUM_CS-1:0]    cs_n,
  output logic [NUM_PAIRS-1:0] oe_n,
  output logic [NUM_PAIRS-1:0] we_n,
  output logic [ADDR_W-1:0]    mem_addr
);

  for (genvar c = 0; c < NUM_CS; c++) begin : g_cs
    assign cs_n[c] = !(busy && act_cfg.csel == 2'(c));
  end

  for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_pair
    assign oe_n[p] = !(busy && !act_write && act_cfg.pair == 1'(p));
    assign we_n[p] = !(busy && act_write && !act_cfg.rd_only &&
                       act_cfg.pair == 1'(p));
  end

  assign mem_addr = busy ?
    {act_addr[ADDR_W-1:ADDR_W-2] ^ {act_cfg.flip_hi, act_cfg.flip_lo},
     act_addr[ADDR_W-3:0]} : '0;

  // R6
  cs_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~cs_n));

  // R10
  oe_we_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (&oe_n) || (&we_n));

  // R7
  rd_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && act_cfg.rd_only |-> &we_n);

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (&cs_n) && (&oe_n) && (&we_n));

endmodule

// File: rtl/membank_ctl.sv
module membank_ctl
  import membank_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int CFG_AW = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic [7:0]        cfg_wdata,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  output logic [2:0]        cs_n,
  output logic [1:0]        oe_n,
  output logic [1:0]        we_n,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              done
);

  logic [NUM_BANKS*8-1:0] cfg_flat;
  logic                   busy;
  bank_cfg_t              act_cfg;
  logic                   act_write;
  logic [ADDR_W-1:0]      act_addr;

  membank_regs #(.CFG_AW(CFG_AW), .REG_BASE(CFG_AW'(8'h14))) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_we   (cfg_we),
    .cfg_addr (cfg_addr),
    .cfg_wdata(cfg_wdata),
    .cfg_flat (cfg_flat)
  );

  membank_seq #(.ADDR_W(ADDR_W)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_valid(req_valid),
    .req_write(req_write),
    .req_addr (req_addr),
    .cfg_flat (cfg_flat),
    .req_ready(req_ready),
    .busy     (busy),
    .done     (done),
    .act_cfg  (act_cfg),
    .act_write(act_write),
    .act_addr (act_addr)
  );

  membank_strobe #(.ADDR_W(ADDR_W)) u_strobe (
    .clk      (clk),
    .rst_n    (rst_n),
    .busy     (busy),
    .act_cfg  (act_cfg),
    .act_write(act_write),
    .act_addr (act_addr),
    .cs_n     (cs_n),
    .oe_n     (oe_n),
    .we_n     (we_n),
    .mem_addr (mem_addr)
  );

endmodule

// File: tb/sim_membank_ctl.sv
`timescale 1ns/1ps
module sim_membank_ctl;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [7:0]  cfg_addr = '0;
  logic [7:0]  cfg_wdata = '0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [19:0] req_addr = '0;
  logic [2:0]  cs_n;
  logic [1:0]  oe_n, we_n;
  logic [19:0] mem_addr;
  logic        done;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  membank_ctl u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .cs_n(cs_n), .oe_n(oe_n),
    .we_n(we_n), .mem_addr(mem_addr), .done(done)
  );

  // {cfg[7:0], bank[1:0], wr, cs_n[2:0], oe_n[1:0], we_n[1:0], waits[2:0], hi[1:0]}
  localparam logic [22:0] VEC [10] = '{
    {8'h00, 2'd0, 1'b0, 3'b110, 2'b10, 2'b11, 3'd4, 2'b00},
    {8'h00, 2'd0, 1'b1, 3'b110, 2'b11, 2'b10, 3'd5, 2'b00},
    {8'h45, 2'd1, 1'b0, 3'b101, 2'b01, 2'b11, 3'd2, 2'b01},
    {8'h45, 2'd1, 1'b1, 3'b101, 2'b11, 2'b01, 3'd3, 2'b01},
    {8'hB6, 2'd2, 1'b0, 3'b011, 2'b01, 2'b11, 3'd1, 2'b01},
    {8'hCA, 2'd3, 1'b1, 3'b011, 2'b11, 2'b11, 3'd1, 2'b11},
    {8'hCA, 2'd3, 1'b0, 3'b011, 2'b10, 2'b11, 3'd0, 2'b11},
    {8'h2F, 2'd2, 1'b1, 3'b111, 2'b11, 2'b11, 3'd5, 2'b00},
    {8'h2F, 2'd2, 1'b0, 3'b111, 2'b01, 2'b11, 3'd4, 2'b00},
    {8'hD0, 2'd0, 1'b1, 3'b110, 2'b11, 2'b10, 3'd1, 2'b01}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr_cfg(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // Observed values of the last access
  int          o_waits;
  logic [2:0]  o_cs;
  logic [1:0]  o_oe, o_we;
  logic [19:0] o_ma;
  logic        o_rdy, o_steady;

  task automatic do_acc(input logic [1:0] bk, input logic wr, input logic [17:0] lo);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = {bk, lo};
    @(negedge clk);
    req_valid = 1'b0;
    o_cs = cs_n; o_oe = oe_n; o_we = we_n; o_ma = mem_addr;
    o_rdy = req_ready; o_steady = 1'b1; o_waits = 0;
    while (!done && o_waits < 20) begin
      @(negedge clk);
      o_waits++;
      if (cs_n !== o_cs || oe_n !== o_oe || we_n !== o_we) o_steady = 1'b0;
    end
    @(negedge clk);
  endtask

  initial begin
    #(5.0 * 100000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [22:0] v;
    logic [17:0] lo;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 cs_n", 32'(cs_n), 32'h7);
    chk("R1 oe_n", 32'(oe_n), 32'h3);
    chk("R1 we_n", 32'(we_n), 32'h3);
    chk("R1 done", 32'(done), 32'h0);
    chk("R1 ready", 32'(req_ready), 32'h1);
    chk("R1 mem_addr", 32'(mem_addr), 32'h0);
    // R1 reset bytes: bank 3 untouched gives slowest read, CS0, pair 0
    do_acc(2'd3, 1'b0, 18'h00011);
    chk("R1 reset cfg waits", 32'(o_waits), 32'd4);
    chk("R1 reset cfg cs", 32'(o_cs), 32'h6);

    // Table walk: R3 R4 R5 R6 R7 R8 R10
    for (int i = 0; i < 10; i++) begin
      v  = VEC[i];
      lo = 18'h15A3C ^ 18'(i * 37);
      wr_cfg(8'h14 + {6'd0, v[14:13]}, v[22:15]);
      do_acc(v[14:13], v[12], lo);
      chk("R6 cs_n", 32'(o_cs), 32'(v[11:9]));
      chk("R7 R10 oe_n", 32'(o_oe), 32'(v[8:7]));
      chk("R7 R10 we_n", 32'(o_we), 32'(v[6:5]));
      chk("R4 R5 waits", 32'(o_waits), 32'(v[4:2]));
      chk("R8 addr hi", 32'(o_ma[19:18]), 32'(v[1:0]));
      chk("R8 addr lo", 32'(o_ma[17:0]), 32'(lo));
      chk("R4 strobes steady", 32'(o_steady), 32'h1);
      chk("R9 ready low busy", 32'(o_rdy), 32'h0);
      chk("R4 idle after done", 32'({done, cs_n, oe_n, we_n, req_ready}), 32'h0FF);
    end

    // R2: writes outside the window are ignored
    wr_cfg(8'h14, 8'h00);
    wr_cfg(8'h13, 8'hC1);
    wr_cfg(8'h18, 8'hC1);
    do_acc(2'd0, 1'b0, 18'h00100);
    chk("R2 ignore waits", 32'(o_waits), 32'd4);
    chk("R2 ignore cs", 32'(o_cs), 32'h6);
    // R2 / R3: each address hits only its own bank
    wr_cfg(8'h16, 8'hC1);
    do_acc(2'd1, 1'b0, 18'h00200);
    chk("R3 bank1 unaffected", 32'(o_waits), 32'd2);
    do_acc(2'd2, 1'b0, 18'h00200);
    chk("R2 bank2 loaded waits", 32'(o_waits), 32'd0);
    chk("R2 bank2 loaded cs", 32'(o_cs), 32'h5);

    // R9: config rewrite in the middle of an access
    wr_cfg(8'h15, 8'h00);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = {2'd1, 18'h00033};
    @(negedge clk);
    req_valid = 1'b0;
    cfg_we = 1'b1; cfg_addr = 8'h15; cfg_wdata = 8'hC2;
    o_waits = 0; o_steady = 1'b1;
    chk("R9 ready low", 32'(req_ready), 32'h0);
    @(negedge clk);
    cfg_we = 1'b0;
    o_waits = 1;
    while (!done && o_waits < 20) begin
      if (cs_n !== 3'b110) o_steady = 1'b0;
      @(negedge clk);
      o_waits++;
    end
    chk("R9 old waits kept", 32'(o_waits), 32'd4);
    chk("R9 old cs kept", 32'(o_steady && cs_n == 3'b110), 32'h1);
    @(negedge clk);
    do_acc(2'd1, 1'b0, 18'h00034);
    chk("R9 new waits", 32'(o_waits), 32'd0);
    chk("R9 new cs", 32'(o_cs), 32'h3);

    // R7 R6: read-only write with reserved CS: nothing moves, timing kept
    wr_cfg(8'h17, 8'h4B);
    do_acc(2'd3, 1'b1, 18'h3FFFF);
    chk("R7 RO we_n", 32'(o_we), 32'h3);
    chk("R6 reserved cs", 32'(o_cs), 32'h7);
    chk("R7 RO write waits", 32'(o_waits), 32'd3);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule